// File: doc/BRIEF.md
# DDR2/DDR3 SDRAM Power-Up Sequencer

This block walks a freshly powered DDR2 or DDR3 SDRAM device through its bring-up before any normal traffic is allowed. A single start pulse launches the sequence. A memory-type input chosen at that moment picks one of two fixed command orders. The block emits abstract commands one at a time over a valid/ready handshake. A physical layer further down turns each command into pin activity.

Mode register commands carry a bank value shifted to a bit position that depends on the device geometry: column-field width, row-field width, sequential or interleaved decoding, and data bus width. Alongside the commands, the block drives two level flags that the downstream logic folds into mode register contents: a DLL-reset request and an off-chip-driver default request. Microsecond-scale pauses are counted in clock cycles, scaled by a clock-frequency parameter. After the normal-mode command and a final dummy write, the block pulses a load strobe that presents the refresh-interval count captured at start. It then raises a done flag.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, cmd_valid, rfsh_load, busy, done, dll_rst and ocd_dflt are all 0.
- R2: Each command's cmd_addr equals its bank value shifted left by OFS. OFS = col_bits + 9, plus (row_bits + 11) only when interleave is 0, plus 1 when narrow_bus is 1 or 2 when it is 0. An extended mode register command to register n uses bank n. Every other command, including the plain mode register set, uses bank 0.
- R3: With ddr3_mode=0 the accepted commands are, in order: NOP, NOP, precharge-all, EMRS(2), EMRS(3), EMRS(1), MRS, precharge-all, refresh, refresh, MRS, EMRS(1), EMRS(1), normal, dummy write. The cmd_op codes are NOP=0, precharge-all=1, MRS=2, EMRS=3, refresh=4, ZQ calibration=5, normal=6, write=7.
- R4: With ddr3_mode=1 the accepted commands are, in order: NOP, NOP, EMRS(2), EMRS(3), EMRS(1), MRS, ZQ calibration, normal, dummy write, using the codes of R3.
- R5: After the first NOP is accepted, cmd_valid stays low for exactly PU2_US*CLK_MHZ cycles (DDR2) or PU3_US*CLK_MHZ cycles (DDR3). After the DDR3 MRS is accepted, it stays low for exactly DLL_US*CLK_MHZ cycles. After any other command, the next command is valid in the following cycle.
- R6: A command is held with stable cmd_op and cmd_addr while cmd_ready is low. The sequence advances by exactly one command per accepting cycle (cmd_valid and cmd_ready both high).
- R7: dll_rst is 1 exactly on the DDR2 commands from the first MRS up to the second refresh inclusive. ocd_dflt is 1 exactly on the first of the two final DDR2 EMRS(1) commands. Both flags are 0 throughout DDR3 and whenever the block is not busy.
- R8: In the cycle after the dummy write is accepted, rfsh_load is high for one cycle with rfsh_count equal to rfsh_cfg as sampled at start. From the next cycle on, done stays high until reset.
- R9: start is ignored while busy or done. Configuration inputs that change after the start cycle do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches the sequence from idle |
| ddr3_mode | input | 1 | 1 selects the DDR3 order, 0 the DDR2 order |
| col_bits | input | 2 | Column-count field |
| row_bits | input | 2 | Row-count field |
| interleave | input | 1 | 1 = interleaved bank decoding (row term dropped) |
| narrow_bus | input | 1 | Data-bus-width flag (adds 1 when set, 2 when clear) |
| rfsh_cfg | input | RF_W | Refresh-interval count to load at the end |
| cmd_ready | input | 1 | Downstream accepts the current command |
| cmd_valid | output | 1 | A command is presented |
| cmd_op | output | 3 | Command code (see R3) |
| cmd_addr | output | ADDR_W | Bank value placed at the computed offset |
| dll_rst | output | 1 | DLL-reset request flag |
| ocd_dflt | output | 1 | Off-chip-driver default request flag |
| rfsh_load | output | 1 | One-cycle strobe loading the refresh count |
| rfsh_count | output | RF_W | Refresh count captured at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
Each pause is counted exactly once per sequence. The offset has 64 geometry combinations, each of which changes every EMRS address. The bench therefore runs the full sequence for every combination of memory type, column field, row field, decoding and bus width, with the clock parameter shrunk so that a complete run costs a few hundred cycles. The ready line cycles through always-ready, one-in-three and a pseudo-random pattern across runs, so that held commands and zero-gap advances both occur. In some runs, mid-sequence, the bench pulses start again and flips every configuration input. The expected addresses still come from the values present at the start cycle.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PREA   = 3'd1,
        OP_MRS    = 3'd2,
        OP_EMRS   = 3'd3,
        OP_REF    = 3'd4,
        OP_ZQCAL  = 3'd5,
        OP_NORMAL = 3'd6,
        OP_WRITE  = 3'd7
    } cmd_op_e;

    typedef enum logic [1:0] {
        PZ_NONE    = 2'd0,
        PZ_POWERUP = 2'd1,
        PZ_DLL     = 2'd2
    } pause_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ISSUE = 3'd1,
        S_PAUSE = 3'd2,
        S_LOAD  = 3'd3,
        S_DONE  = 3'd4
    } state_e;

    typedef struct packed {
        cmd_op_e    op;
        logic [1:0] bank;
        pause_e     pause;
        logic       dll;
        logic       ocd;
        logic       last;
    } step_t;

    localparam int STEP_W = 4;
    localparam int OFS_W  = 5;

    function automatic step_t mk(cmd_op_e op, logic [1:0] bank, pause_e pz,
                                 logic dll, logic ocd, logic last);
        step_t s;
        s.op = op; s.bank = bank; s.pause = pz;
        s.dll = dll; s.ocd = ocd; s.last = last;
        return s;
    endfunction

    function automatic step_t ddr2_step(logic [STEP_W-1:0] i);
        case (i)
            4'd0:    return mk(OP_NOP,    2'd0, PZ_POWERUP, 1'b0, 1'b0, 1'b0);
            4'd1:    return mk(OP_NOP,    2'd0, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd2:    return mk(OP_PREA,   2'd0, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd3:    return mk(OP_EMRS,   2'd2, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd4:    return mk(OP_EMRS,   2'd3, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd5:    return mk(OP_EMRS,   2'd1, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd6:    return mk(OP_MRS,    2'd0, PZ_NONE,    1'b1, 1'b0, 1'b0);
            4'd7:    return mk(OP_PREA,   2'd0, PZ_NONE,    1'b1, 1'b0, 1'b0);
            4'd8:    return mk(OP_REF,    2'd0, PZ_NONE,    1'b1, 1'b0, 1'b0);
            4'd9:    return mk(OP_REF,    2'd0, PZ_NONE,    1'b1, 1'b0, 1'b0);
            4'd10:   return mk(OP_MRS,    2'd0, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd11:   return mk(OP_EMRS,   2'd1, PZ_NONE,    1'b0, 1'b1, 1'b0);
            4'd12:   return mk(OP_EMRS,   2'd1, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd13:   return mk(OP_NORMAL, 2'd0, PZ_NONE,    1'b0, 1'b0, 1'b0);
            default: return mk(OP_WRITE,  2'd0, PZ_NONE,    1'b0, 1'b0, 1'b1);
        endcase
    endfunction

    function automatic step_t ddr3_step(logic [STEP_W-1:0] i);
        case (i)
            4'd0:    return mk(OP_NOP,    2'd0, PZ_POWERUP, 1'b0, 1'b0, 1'b0);
            4'd1:    return mk(OP_NOP,    2'd0, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd2:    return mk(OP_EMRS,   2'd2, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd3:    return mk(OP_EMRS,   2'd3, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd4:    return mk(OP_EMRS,   2'd1, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd5:    return mk(OP_MRS,    2'd0, PZ_DLL,     1'b0, 1'b0, 1'b0);
            4'd6:    return mk(OP_ZQCAL,  2'd0, PZ_NONE,    1'b0, 1'b0, 1'b0);
            4'd7:    return mk(OP_NORMAL, 2'd0, PZ_NONE,    1'b0, 1'b0, 1'b0);
            default: return mk(OP_WRITE,  2'd0, PZ_NONE,    1'b0, 1'b0, 1'b1);
        endcase
    endfunction

endpackage

// File: rtl/ddr_init_ofs.sv
module ddr_init_ofs
    import ddr_init_pkg::*;
(
    input  logic [1:0]       col_bits,
    input  logic [1:0]       row_bits,
    input  logic             interleave,
    input  logic             narrow_bus,
    output logic [OFS_W-1:0] ofs
);
    logic [OFS_W-1:0] row_term;
    logic [OFS_W-1:0] bus_term;

    always_comb begin
        row_term = interleave ? '0 : OFS_W'(row_bits) + OFS_W'(11);
        bus_term = narrow_bus ? OFS_W'(1) : OFS_W'(2);
        ofs      = OFS_W'(col_bits) + OFS_W'(9) + row_term + bus_term;
    end
endmodule

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
    import ddr_init_pkg::*;
(
    input  logic              ddr3,
    input  logic [STEP_W-1:0] idx,
    output step_t             cur
);
    always_comb cur = ddr3 ? ddr3_step(idx) : ddr2_step(idx);
endmodule

// File: rtl/ddr_init_timer.sv
module ddr_init_timer
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int PU2_US  = 200,
    parameter int PU3_US  = 500,
    parameter int DLL_US  = 50
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  pause_e kind,
    input  logic   ddr3,
    output logic   expired
);
    localparam int CYC_PU2 = PU2_US * CLK_MHZ;
    localparam int CYC_PU3 = PU3_US * CLK_MHZ;
    localparam int CYC_DLL = DLL_US * CLK_MHZ;
    localparam int CYC_MAX = (CYC_PU3 > CYC_PU2) ?
                             ((CYC_PU3 > CYC_DLL) ? CYC_PU3 : CYC_DLL) :
                             ((CYC_PU2 > CYC_DLL) ? CYC_PU2 : CYC_DLL);
    localparam int CNT_W   = $clog2(CYC_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;

    always_comb begin
        if (kind == PZ_DLL) span = CNT_W'(CYC_DLL);
        else if (ddr3)      span = CNT_W'(CYC_PU3);
        else                span = CNT_W'(CYC_PU2);
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= span;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == CNT_W'(1));
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int PU2_US  = 200,
    parameter int PU3_US  = 500,
    parameter int DLL_US  = 50,
    parameter int ADDR_W  = 32,
    parameter int RF_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ddr3_mode,
    input  logic [1:0]        col_bits,
    input  logic [1:0]        row_bits,
    input  logic              interleave,
    input  logic              narrow_bus,
    input  logic [RF_W-1:0]   rfsh_cfg,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              dll_rst,
    output logic              ocd_dflt,
    output logic              rfsh_load,
    output logic [RF_W-1:0]   rfsh_count,
    output logic              busy,
    output logic              done
);
    state_e            state;
    logic [STEP_W-1:0] idx;
    logic              ddr3_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [OFS_W-1:0]  ofs_in;
    logic [RF_W-1:0]   rf_q;
    step_t             cur;
    logic              accept;
    logic              tmr_load;
    logic              tmr_exp;

    ddr_init_ofs u_ofs (
        .col_bits   (col_bits),
        .row_bits   (row_bits),
        .interleave (interleave),
        .narrow_bus (narrow_bus),
        .ofs        (ofs_in)
    );

    ddr_init_steps u_steps (
        .ddr3 (ddr3_q),
        .idx  (idx),
        .cur  (cur)
    );

    ddr_init_timer #(
        .CLK_MHZ (CLK_MHZ),
        .PU2_US  (PU2_US),
        .PU3_US  (PU3_US),
        .DLL_US  (DLL_US)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .kind    (cur.pause),
        .ddr3    (ddr3_q),
        .expired (tmr_exp)
    );

    assign accept   = (state == S_ISSUE) && cmd_ready;
    assign tmr_load = accept && (cur.pause != PZ_NONE) && !cur.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            ddr3_q <= 1'b0;
            ofs_q  <= '0;
            rf_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state  <= S_ISSUE;
                    idx    <= '0;
                    ddr3_q <= ddr3_mode;
                    ofs_q  <= ofs_in;
                    rf_q   <= rfsh_cfg;
                end
                S_ISSUE: if (cmd_ready) begin
                    if (cur.last) begin
                        state <= S_LOAD;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= (cur.pause != PZ_NONE) ? S_PAUSE : S_ISSUE;
                    end
                end
                S_PAUSE: if (tmr_exp) state <= S_ISSUE;
                S_LOAD:  state <= S_DONE;
                default: state <= S_DONE;
            endcase
        end
    end

    always_comb begin
        busy       = (state == S_ISSUE) || (state == S_PAUSE) || (state == S_LOAD);
        cmd_valid  = (state == S_ISSUE);
        cmd_op     = cur.op;
        cmd_addr   = ADDR_W'(cur.bank) << ofs_q;
        dll_rst    = ((state == S_ISSUE) || (state == S_PAUSE)) && cur.dll;
        ocd_dflt   = ((state == S_ISSUE) || (state == S_PAUSE)) && cur.ocd;
        rfsh_load  = (state == S_LOAD);
        rfsh_count = rf_q;
        done       = (state == S_DONE);
    end
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              dll_rst,
    input logic              ocd_dflt,
    input logic              rfsh_load,
    input logic              busy,
    input logic              done
);
    p_hold_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_load_once_r8: assert property (@(posedge clk) disable iff (rst)
        rfsh_load |=> !rfsh_load && done);

    p_done_after_load_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(rfsh_load));

    p_flags_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dll_rst && !ocd_dflt);

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(dll_rst && ocd_dflt));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        done && start |=> done && !cmd_valid);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !cmd_valid && !busy && !done && !rfsh_load);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .dll_rst   (dll_rst),
    .ocd_dflt  (ocd_dflt),
    .rfsh_load (rfsh_load),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ    = 1;
    localparam int PU2    = 200;
    localparam int PU3    = 500;
    localparam int DLLW   = 50;
    localparam int ADDR_W = 32;
    localparam int RF_W   = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ddr3_mode = 1'b0;
    logic [1:0] col_bits = '0;
    logic [1:0] row_bits = '0;
    logic interleave = 1'b0;
    logic narrow_bus = 1'b0;
    logic [RF_W-1:0] rfsh_cfg = '0;
    logic cmd_ready = 1'b0;
    logic cmd_valid;
    logic [2:0] cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic dll_rst, ocd_dflt, rfsh_load, busy, done;
    logic [RF_W-1:0] rfsh_count;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_init_seq #(
        .CLK_MHZ(MHZ), .PU2_US(PU2), .PU3_US(PU3), .DLL_US(DLLW),
        .ADDR_W(ADDR_W), .RF_W(RF_W)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .ddr3_mode(ddr3_mode),
        .col_bits(col_bits), .row_bits(row_bits), .interleave(interleave),
        .narrow_bus(narrow_bus), .rfsh_cfg(rfsh_cfg), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .dll_rst(dll_rst), .ocd_dflt(ocd_dflt), .rfsh_load(rfsh_load),
        .rfsh_count(rfsh_count), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected step: op code, bank, pause cycles after acceptance, dll, ocd
    task automatic exp_step(input bit d3, input int i,
                            output int op, output int bank, output int wcyc,
                            output int dll, output int ocd);
        bank = 0; wcyc = 0; dll = 0; ocd = 0;
        if (d3) begin
            case (i)
                0: begin op = 0; wcyc = PU3 * MHZ; end
                1: op = 0;
                2: begin op = 3; bank = 2; end
                3: begin op = 3; bank = 3; end
                4: begin op = 3; bank = 1; end
                5: begin op = 2; wcyc = DLLW * MHZ; end
                6: op = 5;
                7: op = 6;
                default: op = 7;
            endcase
        end else begin
            case (i)
                0: begin op = 0; wcyc = PU2 * MHZ; end
                1: op = 0;
                2: op = 1;
                3: begin op = 3; bank = 2; end
                4: begin op = 3; bank = 3; end
                5: begin op = 3; bank = 1; end
                6: begin op = 2; dll = 1; end
                7: begin op = 1; dll = 1; end
                8: begin op = 4; dll = 1; end
                9: begin op = 4; dll = 1; end
                10: op = 2;
                11: begin op = 3; bank = 1; ocd = 1; end
                12: begin op = 3; bank = 1; end
                13: op = 6;
                default: op = 7;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; cmd_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_valid && !busy && !done && !dll_rst && !ocd_dflt && !rfsh_load,
            "R1 quiet after reset", {cmd_valid, busy, done, dll_rst, ocd_dflt, rfsh_load}, 0);
    endtask

    task automatic run_one(input bit d3, input int col, input int row, input bit il,
                           input bit nar, input int rf, input int rmode, input bit poke);
        int n, ofs, gap, prev_w, op, bank, w, dl, oc;
        bit acc, rdy;
        longint ea;
        n = d3 ? 9 : 15;
        ofs = col + 9 + (il ? 0 : row + 11) + (nar ? 1 : 2);
        // at a negedge with the block idle
        ddr3_mode = d3; col_bits = col[1:0]; row_bits = row[1:0];
        interleave = il; narrow_bus = nar; rfsh_cfg = rf[RF_W-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        prev_w = 0;
        for (int i = 0; i < n; i++) begin
            exp_step(d3, i, op, bank, w, dl, oc);
            gap = 0; acc = 0;
            while (!acc) begin
                start = 1'b0;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (rmode)
                    0: rdy = 1'b1;
                    1: rdy = ($time / CLK_PERIOD) % 3 == 0;
                    default: rdy = lfsr[0];
                endcase
                cmd_ready = rdy;
                if (poke && i == 3 && !rdy) begin
                    // R9: restart and config change mid-run must be ignored
                    start = 1'b1; ddr3_mode = ~d3; col_bits = ~col[1:0];
                    row_bits = ~row[1:0]; interleave = ~il; narrow_bus = ~nar;
                    rfsh_cfg = ~rf[RF_W-1:0];
                end
                if (cmd_valid && rdy) begin
                    acc = 1;
                    ea = longint'(bank) << ofs;
                    chk(cmd_op == op[2:0], d3 ? "R4 op order" : "R3 op order", cmd_op, op);
                    chk(cmd_addr == ea[ADDR_W-1:0], "R2 bank offset address", cmd_addr, ea);
                    chk(dll_rst == dl[0] && ocd_dflt == oc[0], "R7 flags",
                        {dll_rst, ocd_dflt}, {dl[0], oc[0]});
                    chk(gap == prev_w, "R5/R6 gap before command", gap, prev_w);
                end else if (!cmd_valid) begin
                    gap++;
                end
                @(negedge clk);
            end
            prev_w = w;
        end
        start = 1'b0; cmd_ready = 1'b0;
        chk(rfsh_load && rfsh_count == rf[RF_W-1:0] && !done, "R8 refresh load",
            {rfsh_load, rfsh_count}, {1'b1, rf[RF_W-1:0]});
        @(negedge clk);
        chk(done && !rfsh_load && !cmd_valid && !dll_rst && !ocd_dflt, "R8 done",
            {done, rfsh_load, cmd_valid}, 3'b100);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(done && !cmd_valid && !busy, "R9 start after done ignored",
            {done, cmd_valid, busy}, 3'b100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int k;
        k = 0;
        @(negedge clk);
        chk(!cmd_valid && !busy && !done && !dll_rst && !ocd_dflt, "R1 in reset",
            {cmd_valid, busy, done}, 0);
        for (int d = 0; d < 2; d++)
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    for (int il = 0; il < 2; il++)
                        for (int nb = 0; nb < 2; nb++) begin
                            do_reset();
                            run_one(d[0], c, r, il[0], nb[0], (k * 37 + 5) % 4096,
                                    k % 3, (k % 5) == 2);
                            k++;
                        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule